// File: doc/BRIEF.md
# H-Bridge Control Mode Decoder

This block converts the logic-level controls of a motor H-bridge into on/off commands for its four power switches. Each of the two half-bridges (legs) has a high-side and a low-side switch. The block takes an active-low sleep input, two control inputs, a two-bit code for a three-level mode strap and a current-regulation request. It produces a high-side and a low-side enable for each leg.

A control mode is fixed once, on the first clock edge after reset is released, and it selects one of three decode tables: phase/enable, PWM, or independent half-bridge. The decoded target of each leg (off, low side on, high side on) passes through a per-leg break-before-make sequencer. Whenever a leg changes from one switch to the other, the sequencer holds both of that leg's switches off for a fixed number of cycles.

Index 0 of every output vector is OUT1 and index 1 is OUT2. A leg that has both enables at 0 is Hi-Z.

Top module: `hb_ctrl_top`

## Requirements
- R1: The mode code `mode_code_i` is captured on the first rising clock edge after `rst_ni` rises. 2'b00 selects phase/enable, 2'b01 selects PWM, and 2'b10 or 2'b11 selects independent half-bridge. Later changes of the code have no effect. While in reset, all enables are 0.
- R2: `sleep_ni`=0 forces all four enables to 0 from the next clock edge, in every mode.
- R3: In phase/enable mode, `ctl1_i` is the enable and `ctl2_i` is the phase. Enable=0 turns on both low sides (brake). Enable=1 with phase=1 gives OUT1 high and OUT2 low (forward). Enable=1 with phase=0 gives OUT1 low and OUT2 high (reverse).
- R4: In PWM mode, the pair {ctl1_i,ctl2_i} decodes as follows: 00 turns all switches off (coast), 01 gives OUT1 low and OUT2 high, 10 gives OUT1 high and OUT2 low, and 11 turns on both low sides.
- R5: In independent mode, `ctl1_i` controls OUT1 and `ctl2_i` controls OUT2. A control value of 1 turns on that leg's high side and 0 turns on its low side.
- R6: In phase/enable and PWM modes, `reg_req_i`=1 forces brake (both low sides on) until the request is released. Entry into brake still goes through dead time.
- R7: In independent mode, `reg_req_i` has no effect on the outputs.
- R8: When a leg changes from one switch to the opposite switch, both of its enables stay 0 for exactly DEAD_CYC cycles (default 4), and the new switch turns on at the next edge.
- R9: The high-side and low-side enables of one leg are never 1 in the same cycle.
- R10: If no dead time is pending, a leg follows a new target on the next clock edge. A leg that has been off for at least DEAD_CYC cycles counts as having no dead time pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_ni | input | 1 | Active-low sleep; 0 turns all switches off |
| ctl1_i | input | 1 | Control input 1 (enable / IN1) |
| ctl2_i | input | 1 | Control input 2 (phase / IN2) |
| mode_code_i | input | 2 | Encoded three-level mode strap |
| reg_req_i | input | 1 | Current-regulation brake request |
| hs_en_o | output | 2 | High-side enables, [0]=OUT1, [1]=OUT2 |
| ls_en_o | output | 2 | Low-side enables, [0]=OUT1, [1]=OUT2 |

## Verification
A regulation request and dead-time sequencing can act in the same cycle. The bench raises the request while a leg is driving its high side, which forces a high-to-low change. It then checks that both switches of that leg stay off during the dead-time window before the brake appears. A phase reversal makes both legs swap sides at once, and the bench checks that both legs go off together for exactly DEAD_CYC cycles before each turns on its opposite switch. The no-overlap invariant is sampled on every cycle of the run.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    MODE_PHEN  = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_INDEP = 2'd2
  } hb_mode_e;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_LOW  = 2'd1,
    LEG_HIGH = 2'd2
  } leg_cmd_e;

  function automatic hb_mode_e code_to_mode(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_PHEN;
      2'b01:   return MODE_PWM;
      default: return MODE_INDEP;
    endcase
  endfunction
endpackage

// File: rtl/hb_mode_latch.sv
module hb_mode_latch
  import hb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  output hb_mode_e   mode_o,
  output logic       valid_o
);
  hb_mode_e mode_q;
  logic     valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_PHEN;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      mode_q  <= code_to_mode(code_i);
      valid_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  // R1: once captured, the mode never moves
  p_mode_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q)) |-> $stable(mode_q));
endmodule

// File: rtl/hb_decoder.sv
module hb_decoder
  import hb_pkg::*;
(
  input  hb_mode_e mode_i,
  input  logic     valid_i,
  input  logic     sleep_ni,
  input  logic     ctl1_i,
  input  logic     ctl2_i,
  input  logic     reg_req_i,
  output leg_cmd_e tgt_o [2]
);
  always_comb begin
    tgt_o[0] = LEG_OFF;
    tgt_o[1] = LEG_OFF;
    if (valid_i && sleep_ni) begin
      unique case (mode_i)
        MODE_PHEN: begin
          if (reg_req_i || !ctl1_i) begin
            tgt_o[0] = LEG_LOW;
            tgt_o[1] = LEG_LOW;
          end else begin
            tgt_o[0] = ctl2_i ? LEG_HIGH : LEG_LOW;
            tgt_o[1] = ctl2_i ? LEG_LOW : LEG_HIGH;
          end
        end
        MODE_PWM: begin
          if (reg_req_i) begin
            tgt_o[0] = LEG_LOW;
            tgt_o[1] = LEG_LOW;
          end else begin
            case ({ctl1_i, ctl2_i})
              2'b01: begin tgt_o[0] = LEG_LOW;  tgt_o[1] = LEG_HIGH; end
              2'b10: begin tgt_o[0] = LEG_HIGH; tgt_o[1] = LEG_LOW;  end
              2'b11: begin tgt_o[0] = LEG_LOW;  tgt_o[1] = LEG_LOW;  end
              default: ;
            endcase
          end
        end
        MODE_INDEP: begin
          tgt_o[0] = ctl1_i ? LEG_HIGH : LEG_LOW;
          tgt_o[1] = ctl2_i ? LEG_HIGH : LEG_LOW;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hb_dead_time.sv
module hb_dead_time
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_cmd_e tgt_i,
  output logic     hs_o,
  output logic     ls_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEAD_CYC);

  leg_cmd_e      out_q, out_d, last_q, last_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d  = out_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    if (out_q == LEG_OFF) begin
      if (cnt_q < CNT_MAX) cnt_d = cnt_q + 1'b1;
      // same side again is safe; opposite side waits out the gap
      if (tgt_i != LEG_OFF && (tgt_i == last_q || cnt_q >= CNT_MAX)) out_d = tgt_i;
    end else if (tgt_i != out_q) begin
      out_d  = LEG_OFF;
      last_d = out_q;
      cnt_d  = CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= LEG_OFF;
      last_q <= LEG_OFF;
      cnt_q  <= CNT_MAX;
    end else begin
      out_q  <= out_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hs_o = (out_q == LEG_HIGH);
  assign ls_o = (out_q == LEG_LOW);

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  // R8: a switch never turns on straight after its partner
  p_gap_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ls_o));
  p_gap_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_o) |-> !$past(hs_o));
endmodule

// File: rtl/hb_ctrl_top.sv
module hb_ctrl_top
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_ni,
  input  logic       ctl1_i,
  input  logic       ctl2_i,
  input  logic [1:0] mode_code_i,
  input  logic       reg_req_i,
  output logic [1:0] hs_en_o,
  output logic [1:0] ls_en_o
);
  localparam int unsigned LEGS = 2;

  hb_mode_e mode;
  logic     mode_valid;
  leg_cmd_e tgt [LEGS];

  hb_mode_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (mode_code_i),
    .mode_o (mode),
    .valid_o(mode_valid)
  );

  hb_decoder u_dec (
    .mode_i   (mode),
    .valid_i  (mode_valid),
    .sleep_ni (sleep_ni),
    .ctl1_i   (ctl1_i),
    .ctl2_i   (ctl2_i),
    .reg_req_i(reg_req_i),
    .tgt_o    (tgt)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hb_dead_time #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tgt_i (tgt[g]),
      .hs_o  (hs_en_o[g]),
      .ls_o  (ls_en_o[g])
    );
  end

  p_sleep_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |=> (hs_en_o == '0 && ls_en_o == '0));
  // R7: regulation request never disturbs a settled independent leg
  p_reg_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_valid && mode == MODE_INDEP && $rose(reg_req_i) && $stable(ctl1_i)
     && $stable(ctl2_i) && $stable(sleep_ni) && (hs_en_o | ls_en_o) == 2'b11)
    |=> $stable(hs_en_o) && $stable(ls_en_o));
endmodule

// File: tb/hb_ctrl_top_test.sv
module hb_ctrl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_n = 1'b1;
  logic       c1 = 1'b0, c2 = 1'b0, rq = 1'b0;
  logic [1:0] code = 2'b00;
  logic [1:0] hs, ls;

  int n_chk = 0, n_fail = 0;
  int overlap_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] hs;
    logic [1:0] ls;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_ctrl_top #(.DEAD_CYC(DT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .ctl1_i(c1), .ctl2_i(c2),
    .mode_code_i(code), .reg_req_i(rq), .hs_en_o(hs), .ls_en_o(ls)
  );

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && ((hs & ls) != 2'b00)) overlap_cnt++;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (hs !== e.hs || ls !== e.ls) begin
        n_fail++;
        $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", e.tag, hs, ls, e.hs, e.ls);
      end
    end
  end

  task automatic expect_out(input logic [1:0] h, input logic [1:0] l, input string tag);
    exp_t e;
    e.hs = h; e.ls = l; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drive(input logic s, input logic a, input logic b, input logic r);
    @(negedge clk);
    sleep_n = s; c1 = a; c2 = b; rq = r;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; sleep_n = 1'b1; c1 = a; c2 = b; rq = 1'b0; code = m;
    settle(2);
    rst_n = 1'b1;
    expect_out(2'b00, 2'b00, "R1 reset state");
  endtask

  initial begin
    // phase/enable
    do_reset(2'b00, 1'b0, 1'b0);
    settle(6);  expect_out(2'b00, 2'b11, "R3 brake en=0");
    drive(1, 1, 1, 0);
    settle(6);  expect_out(2'b01, 2'b10, "R3 forward");
    drive(1, 1, 0, 0);
    settle(DT); expect_out(2'b00, 2'b00, "R8 both legs off in gap");
    settle(1);  expect_out(2'b10, 2'b01, "R8 R3 reverse after gap");
    // regulation and dead time in the same window
    drive(1, 1, 0, 1);
    settle(DT); expect_out(2'b00, 2'b01, "R6 R8 leg1 off before brake");
    settle(1);  expect_out(2'b00, 2'b11, "R6 brake on request");
    drive(1, 1, 0, 0);
    settle(6);  expect_out(2'b10, 2'b01, "R6 release restores reverse");
    drive(0, 1, 0, 0);
    settle(1);  expect_out(2'b00, 2'b00, "R2 sleep in phase/enable");

    // PWM
    do_reset(2'b01, 1'b0, 1'b0);
    settle(3);  expect_out(2'b00, 2'b00, "R4 coast 00");
    code = 2'b00;
    settle(3);  expect_out(2'b00, 2'b00, "R1 late code change ignored");
    drive(1, 1, 0, 0);
    settle(1);  expect_out(2'b01, 2'b10, "R10 R4 forward in one cycle");
    drive(1, 1, 1, 0);
    settle(6);  expect_out(2'b00, 2'b11, "R4 brake 11");
    drive(1, 0, 1, 0);
    settle(6);  expect_out(2'b10, 2'b01, "R4 reverse 01");
    drive(1, 0, 1, 1);
    settle(6);  expect_out(2'b00, 2'b11, "R6 PWM brake on request");
    drive(1, 0, 0, 0);
    settle(1);  expect_out(2'b00, 2'b00, "R4 coast from brake");

    // independent
    do_reset(2'b10, 1'b1, 1'b0);
    settle(3);  expect_out(2'b01, 2'b10, "R5 indep 1/0");
    drive(1, 0, 1, 0);
    settle(DT); expect_out(2'b00, 2'b00, "R8 indep gap");
    settle(1);  expect_out(2'b10, 2'b01, "R5 indep 0/1");
    drive(1, 0, 1, 1);
    settle(1);  expect_out(2'b10, 2'b01, "R7 request ignored next cycle");
    settle(5);  expect_out(2'b10, 2'b01, "R7 request ignored later");
    drive(0, 0, 1, 1);
    settle(1);  expect_out(2'b00, 2'b00, "R2 sleep in indep");

    // code 11 maps to independent
    do_reset(2'b11, 1'b1, 1'b1);
    settle(3);  expect_out(2'b11, 2'b00, "R1 R5 code 11 indep");

    settle(2);
    n_chk++;
    if (overlap_cnt != 0) begin
      n_fail++;
      $display("FAIL R9 overlap cycles=%0d expected 0", overlap_cnt);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule